// File: doc/BRIEF.md
# Tagged Set-Associative Address Translation Unit

This block translates a virtual address into a physical address for one memory access at a time. Each request carries the address, an access kind (load, store or instruction fetch) and the privilege ring the requester runs at. The virtual page number indexes one entry in every way of a set-associative table. An entry counts as a hit when its page tag matches and its address-space identifier (ASID) is both nonzero and present in a four-byte ring map. The position of that byte in the map, 0 to 3, is the entry's ring. The block returns the physical address, or a fault with a cause code for a miss, multiple hits, a ring violation or a denied permission.

When a lookup misses, the block can load one page-table entry (PTE) through an external request/response port. It writes that entry into a way chosen by a round-robin pointer and then repeats the lookup. A loaded entry takes its ASID from the ring map byte selected by the PTE's ring field. The unit handles one request at a time and ignores new requests while a refill is in progress.

Top module: `tlb_lookup_unit`

## Requirements
- R1: After reset, `resp_valid`, `pte_req` and `busy` are low, the ring map holds 0x04030201 (byte k is the ASID of ring k), and every entry holds ASID 0, so an entry hits only after it has been refilled.
- R2: A way hits only when its stored tag equals the virtual page number, its ASID is nonzero, and the ASID equals one byte of the ring map. The hit's ring is the index of that byte. An entry whose ASID is in no byte does not hit.
- R3: A miss that is not refilled faults with cause 24 for a load or store and 16 for a fetch.
- R4: Two or more hitting ways fault with cause 25 for a load or store and 17 for a fetch.
- R5: A single hit whose ring is numerically below `req_ring` faults with cause 26 for data and 18 for fetch. This check takes priority over the permission check.
- R6: Attribute decode: a value below 12 grants read, with bit 0 adding execute and bit 1 adding write. Value 13 grants read and write. Every other value grants nothing. A load needs read, a store needs write and a fetch needs execute. `req_kind` is encoded 0 = load, 1 = store, 2 = fetch.
- R7: A denied access faults with cause 28 for a load, 29 for a store and 20 for a fetch.
- R8: On success, `resp_paddr` is the entry's physical page (PTE bits [31:12]) concatenated with virtual address bits [11:0].
- R9: A miss is refilled unless `req_ring` is 0 and the address has the same bits [31:22] as `pt_base`. The PTE address is `(pt_base | vaddr>>10)` with bits [1:0] cleared. No response is given while the refill is in progress.
- R10: A refill increments the way pointer (reset 0, wrapping modulo the number of ways) and writes into the new pointer value. The new entry takes its ring from PTE bits [5:4], its attribute from PTE bits [3:0], and its ASID from the ring map byte of that ring.
- R11: A request that hits, or faults without a refill, gets `resp_valid` on the cycle after it is accepted. `pte_req` and `pte_addr` hold steady until `pte_ack`. The response follows two cycles after the cycle in which `pte_ack` is high.
- R12: While `busy` is high, `req_valid` is ignored. Such a request produces no response and no PTE request.
- R13: A write through `ring_asid_we` replaces the ring map, and the new map applies to the next lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe, accepted when `busy` is low |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_ring | input | 2 | Privilege ring of the requester |
| ring_asid_we | input | 1 | Ring map write strobe |
| ring_asid_wdata | input | 32 | New ring map, one ASID byte per ring |
| pt_base | input | 32 | Page-table virtual base |
| pte_req | output | 1 | PTE read request, held until acknowledged |
| pte_addr | output | 32 | PTE read address |
| pte_ack | input | 1 | PTE read response strobe |
| pte_data | input | 32 | PTE value returned with `pte_ack` |
| busy | output | 1 | Refill in progress; requests are ignored |
| resp_valid | output | 1 | One-cycle result strobe |
| resp_fault | output | 1 | Result is a fault |
| resp_cause | output | 6 | Fault cause code, 0 when no fault |
| resp_paddr | output | 32 | Physical address, valid when no fault |

## Verification
Lookups are run against entries built by refills with every attribute class (0, 1, 2, 3, 12, 13), under all three access kinds and several requester rings. These runs separate the permission decode from the ring comparison, and they also check that the privilege fault takes precedence. Addresses inside and outside the page-table base region, at ring 0 and above, show when a miss is refilled and what PTE address results. A sequence of six refills shows the way pointer wrapping. Rewriting the ring map first orphans an entry, so it misses and is refilled into another way. It then makes both the orphaned entry and the new one visible at once, which raises the multi-hit faults. A request held high during a slow refill shows that busy-time requests are dropped.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_RETRY = 2'd2
  } xlt_state_e;

  localparam int RING_CNT = 4;

  localparam logic [5:0] CAUSE_NONE    = 6'd0;
  localparam logic [5:0] CAUSE_I_MISS  = 6'd16;
  localparam logic [5:0] CAUSE_I_MULTI = 6'd17;
  localparam logic [5:0] CAUSE_I_PRIV  = 6'd18;
  localparam logic [5:0] CAUSE_I_PROH  = 6'd20;
  localparam logic [5:0] CAUSE_D_MISS  = 6'd24;
  localparam logic [5:0] CAUSE_D_MULTI = 6'd25;
  localparam logic [5:0] CAUSE_D_PRIV  = 6'd26;
  localparam logic [5:0] CAUSE_LD_PROH = 6'd28;
  localparam logic [5:0] CAUSE_ST_PROH = 6'd29;

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
  parameter int WAYS   = 4,
  parameter int SETS   = 8,
  parameter int TAG_W  = 20,
  parameter int PPN_W  = 20,
  parameter int ASID_W = 8,
  parameter int ATTR_W = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [IDX_W-1:0]              rd_idx,
  input  logic                          wr_en,
  input  logic [WAY_W-1:0]              wr_way,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [TAG_W-1:0]              wr_tag,
  input  logic [PPN_W-1:0]              wr_ppn,
  input  logic [ASID_W-1:0]             wr_asid,
  input  logic [ATTR_W-1:0]             wr_attr,
  output logic [WAYS-1:0][TAG_W-1:0]    way_tag,
  output logic [WAYS-1:0][PPN_W-1:0]    way_ppn,
  output logic [WAYS-1:0][ASID_W-1:0]   way_asid,
  output logic [WAYS-1:0][ATTR_W-1:0]   way_attr
);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [PPN_W-1:0]  ppn_q  [SETS];
    logic [ASID_W-1:0] asid_q [SETS];
    logic [ATTR_W-1:0] attr_q [SETS];

    for (genvar s = 0; s < SETS; s++) begin : g_set
      logic sel_en;
      assign sel_en = wr_en && (wr_way == WAY_W'(w)) && (wr_idx == IDX_W'(s));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          tag_q[s]  <= '0;
          ppn_q[s]  <= '0;
          asid_q[s] <= '0;
          attr_q[s] <= '0;
        end else if (sel_en) begin
          tag_q[s]  <= wr_tag;
          ppn_q[s]  <= wr_ppn;
          asid_q[s] <= wr_asid;
          attr_q[s] <= wr_attr;
        end
      end
    end

    assign way_tag[w]  = tag_q[rd_idx];
    assign way_ppn[w]  = ppn_q[rd_idx];
    assign way_asid[w] = asid_q[rd_idx];
    assign way_attr[w] = attr_q[rd_idx];
  end

endmodule

// File: rtl/tlb_hit_resolve.sv
module tlb_hit_resolve #(
  parameter int WAYS   = 4,
  parameter int TAG_W  = 20,
  parameter int PPN_W  = 20,
  parameter int ASID_W = 8,
  parameter int ATTR_W = 4,
  localparam int CNT_W = $clog2(WAYS + 1)
) (
  input  logic [TAG_W-1:0]              lk_tag,
  input  logic [WAYS-1:0][TAG_W-1:0]    way_tag,
  input  logic [WAYS-1:0][PPN_W-1:0]    way_ppn,
  input  logic [WAYS-1:0][ASID_W-1:0]   way_asid,
  input  logic [WAYS-1:0][ATTR_W-1:0]   way_attr,
  input  logic [4*ASID_W-1:0]           ring_map,
  output logic                          hit_any,
  output logic                          hit_multi,
  output logic [1:0]                    hit_ring,
  output logic [PPN_W-1:0]              hit_ppn,
  output logic [ATTR_W-1:0]             hit_attr
);

  logic [WAYS-1:0]      way_hit;
  logic [WAYS-1:0][1:0] way_ring;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    logic       map_ok;
    logic [1:0] map_ring;

    // lowest matching byte wins
    always_comb begin
      map_ok   = 1'b0;
      map_ring = 2'd0;
      for (int r = 3; r >= 0; r--) begin
        if (ring_map[r*ASID_W +: ASID_W] == way_asid[w]) begin
          map_ok   = 1'b1;
          map_ring = 2'(r);
        end
      end
    end

    assign way_hit[w]  = map_ok && (way_asid[w] != '0) && (way_tag[w] == lk_tag);
    assign way_ring[w] = map_ring;
  end

  logic [CNT_W-1:0] n_hits;

  always_comb begin
    n_hits   = '0;
    hit_ring = 2'd0;
    hit_ppn  = '0;
    hit_attr = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_hit[w]) begin
        n_hits   = n_hits + CNT_W'(1);
        hit_ring = way_ring[w];
        hit_ppn  = way_ppn[w];
        hit_attr = way_attr[w];
      end
    end
  end

  assign hit_any   = (n_hits != '0);
  assign hit_multi = (n_hits > CNT_W'(1));

endmodule

// File: rtl/tlb_perm_decode.sv
module tlb_perm_decode #(
  parameter int ATTR_W = 4
) (
  input  logic [ATTR_W-1:0] attr,
  output logic              can_rd,
  output logic              can_wr,
  output logic              can_ex
);

  always_comb begin
    can_rd = 1'b0;
    can_wr = 1'b0;
    can_ex = 1'b0;
    if (attr < ATTR_W'(12)) begin
      can_rd = 1'b1;
      can_ex = attr[0];
      can_wr = attr[1];
    end else if (attr == ATTR_W'(13)) begin
      can_rd = 1'b1;
      can_wr = 1'b1;
    end
  end

endmodule

// File: rtl/tlb_lookup_unit.sv
module tlb_lookup_unit
  import tlb_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int WAYS      = 4,
  parameter int SETS      = 8,
  parameter int ASID_W    = 8,
  parameter int ATTR_W    = 4,
  parameter logic [4*ASID_W-1:0] RING_MAP_RST = 32'h0403_0201
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [VA_W-1:0]       req_vaddr,
  input  logic [1:0]            req_kind,
  input  logic [1:0]            req_ring,
  input  logic                  ring_asid_we,
  input  logic [4*ASID_W-1:0]   ring_asid_wdata,
  input  logic [VA_W-1:0]       pt_base,
  output logic                  pte_req,
  output logic [VA_W-1:0]       pte_addr,
  input  logic                  pte_ack,
  input  logic [VA_W-1:0]       pte_data,
  output logic                  busy,
  output logic                  resp_valid,
  output logic                  resp_fault,
  output logic [5:0]            resp_cause,
  output logic [VA_W-1:0]       resp_paddr
);

  localparam int TAG_W      = VA_W - PAGE_BITS;
  localparam int PPN_W      = VA_W - PAGE_BITS;
  localparam int IDX_W      = $clog2(SETS);
  localparam int WAY_W      = $clog2(WAYS);
  localparam int PTE_SHIFT  = PAGE_BITS - 2;
  localparam int REGION_LSB = 2 * PAGE_BITS - 2;

  // ---------------- state registers ----------------
  xlt_state_e          st_q, st_d;
  logic [VA_W-1:0]     q_vaddr;
  logic [1:0]          q_kind, q_ring;
  logic                q_load;
  logic                pte_req_q, pte_req_d;
  logic [VA_W-1:0]     pte_addr_q, pte_addr_d;
  logic [WAY_W-1:0]    way_ptr_q, way_ptr_d;
  logic [4*ASID_W-1:0] ring_map_q;
  logic                resp_set;
  logic                resp_valid_q;
  logic                resp_fault_q;
  logic [5:0]          resp_cause_q;
  logic [VA_W-1:0]     resp_paddr_q;

  // ---------------- lookup operand select ----------------
  logic            in_retry;
  logic [VA_W-1:0] lk_vaddr;
  logic [1:0]      lk_kind, lk_ring;

  assign in_retry = (st_q == ST_RETRY);
  assign lk_vaddr = in_retry ? q_vaddr : req_vaddr;
  assign lk_kind  = in_retry ? q_kind  : req_kind;
  assign lk_ring  = in_retry ? q_ring  : req_ring;

  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag;
  assign lk_idx = lk_vaddr[PAGE_BITS +: IDX_W];
  assign lk_tag = lk_vaddr[VA_W-1:PAGE_BITS];

  // ---------------- entry storage ----------------
  logic                        wr_en;
  logic [WAY_W-1:0]            wr_way;
  logic [1:0]                  pte_ring;
  logic [ASID_W-1:0]           fill_asid;
  logic [WAYS-1:0][TAG_W-1:0]  way_tag;
  logic [WAYS-1:0][PPN_W-1:0]  way_ppn;
  logic [WAYS-1:0][ASID_W-1:0] way_asid;
  logic [WAYS-1:0][ATTR_W-1:0] way_attr;

  assign wr_way    = way_ptr_q + WAY_W'(1);
  assign pte_ring  = pte_data[5:4];
  assign fill_asid = ring_map_q[pte_ring*ASID_W +: ASID_W];

  tlb_entry_store #(
    .WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .PPN_W(PPN_W),
    .ASID_W(ASID_W), .ATTR_W(ATTR_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (lk_idx),
    .wr_en    (wr_en),
    .wr_way   (wr_way),
    .wr_idx   (q_vaddr[PAGE_BITS +: IDX_W]),
    .wr_tag   (q_vaddr[VA_W-1:PAGE_BITS]),
    .wr_ppn   (pte_data[VA_W-1:PAGE_BITS]),
    .wr_asid  (fill_asid),
    .wr_attr  (pte_data[ATTR_W-1:0]),
    .way_tag  (way_tag),
    .way_ppn  (way_ppn),
    .way_asid (way_asid),
    .way_attr (way_attr)
  );

  logic unused_pte_bits;
  assign unused_pte_bits = ^pte_data[PAGE_BITS-1:6];

  // ---------------- hit resolution and rights ----------------
  logic              hit_any, hit_multi;
  logic [1:0]        hit_ring;
  logic [PPN_W-1:0]  hit_ppn;
  logic [ATTR_W-1:0] hit_attr;

  tlb_hit_resolve #(
    .WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W), .ASID_W(ASID_W), .ATTR_W(ATTR_W)
  ) u_resolve (
    .lk_tag    (lk_tag),
    .way_tag   (way_tag),
    .way_ppn   (way_ppn),
    .way_asid  (way_asid),
    .way_attr  (way_attr),
    .ring_map  (ring_map_q),
    .hit_any   (hit_any),
    .hit_multi (hit_multi),
    .hit_ring  (hit_ring),
    .hit_ppn   (hit_ppn),
    .hit_attr  (hit_attr)
  );

  logic can_rd, can_wr, can_ex;

  tlb_perm_decode #(.ATTR_W(ATTR_W)) u_perm (
    .attr   (hit_attr),
    .can_rd (can_rd),
    .can_wr (can_wr),
    .can_ex (can_ex)
  );

  // ---------------- fault classification ----------------
  logic       is_fetch, granted, lk_fault, fill_ok;
  logic [5:0] lk_cause;
  logic [VA_W-1:0] fill_addr;

  assign is_fetch = (lk_kind == ACC_FETCH);

  always_comb begin
    case (lk_kind)
      ACC_LOAD:  granted = can_rd;
      ACC_STORE: granted = can_wr;
      ACC_FETCH: granted = can_ex;
      default:   granted = 1'b0;
    endcase
  end

  always_comb begin
    lk_fault = 1'b1;
    lk_cause = CAUSE_NONE;
    if (hit_multi) begin
      lk_cause = is_fetch ? CAUSE_I_MULTI : CAUSE_D_MULTI;
    end else if (!hit_any) begin
      lk_cause = is_fetch ? CAUSE_I_MISS : CAUSE_D_MISS;
    end else if (hit_ring < lk_ring) begin
      lk_cause = is_fetch ? CAUSE_I_PRIV : CAUSE_D_PRIV;
    end else if (!granted) begin
      case (lk_kind)
        ACC_STORE: lk_cause = CAUSE_ST_PROH;
        ACC_FETCH: lk_cause = CAUSE_I_PROH;
        default:   lk_cause = CAUSE_LD_PROH;
      endcase
    end else begin
      lk_fault = 1'b0;
    end
  end

  assign fill_ok = !hit_any &&
                   ((lk_ring != 2'd0) ||
                    (lk_vaddr[VA_W-1:REGION_LSB] != pt_base[VA_W-1:REGION_LSB]));
  assign fill_addr = (pt_base | (lk_vaddr >> PTE_SHIFT)) & ~VA_W'(3);

  // ---------------- next state ----------------
  always_comb begin
    st_d       = st_q;
    q_load     = 1'b0;
    pte_req_d  = pte_req_q;
    pte_addr_d = pte_addr_q;
    way_ptr_d  = way_ptr_q;
    wr_en      = 1'b0;
    resp_set   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (fill_ok) begin
            st_d       = ST_FILL;
            q_load     = 1'b1;
            pte_req_d  = 1'b1;
            pte_addr_d = fill_addr;
          end else begin
            resp_set = 1'b1;
          end
        end
      end
      ST_FILL: begin
        if (pte_ack) begin
          wr_en     = 1'b1;
          way_ptr_d = wr_way;
          pte_req_d = 1'b0;
          st_d      = ST_RETRY;
        end
      end
      ST_RETRY: begin
        resp_set = 1'b1;
        st_d     = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      q_vaddr      <= '0;
      q_kind       <= '0;
      q_ring       <= '0;
      pte_req_q    <= 1'b0;
      pte_addr_q   <= '0;
      way_ptr_q    <= '0;
      ring_map_q   <= RING_MAP_RST;
      resp_valid_q <= 1'b0;
      resp_fault_q <= 1'b0;
      resp_cause_q <= CAUSE_NONE;
      resp_paddr_q <= '0;
    end else begin
      st_q         <= st_d;
      pte_req_q    <= pte_req_d;
      pte_addr_q   <= pte_addr_d;
      way_ptr_q    <= way_ptr_d;
      resp_valid_q <= resp_set;
      if (q_load) begin
        q_vaddr <= req_vaddr;
        q_kind  <= req_kind;
        q_ring  <= req_ring;
      end
      if (ring_asid_we) begin
        ring_map_q <= ring_asid_wdata;
      end
      if (resp_set) begin
        resp_fault_q <= lk_fault;
        resp_cause_q <= lk_cause;
        resp_paddr_q <= lk_fault ? '0 : {hit_ppn, lk_vaddr[PAGE_BITS-1:0]};
      end
    end
  end

  assign pte_req    = pte_req_q;
  assign pte_addr   = pte_addr_q;
  assign busy       = (st_q != ST_IDLE);
  assign resp_valid = resp_valid_q;
  assign resp_fault = resp_fault_q;
  assign resp_cause = resp_cause_q;
  assign resp_paddr = resp_paddr_q;

  // ---------------- assertions ----------------
  AST_RESP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !busy) else $error("response while busy"); // R11

  AST_PTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pte_req && !pte_ack) |=> (pte_req && $stable(pte_addr))) else $error("pte request dropped"); // R11

  AST_PTE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    pte_req |-> (pte_addr[1:0] == 2'b00)) else $error("pte address unaligned"); // R9

  AST_FILL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    pte_req |-> !resp_valid) else $error("response during refill"); // R9

  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pte_req) |=> !pte_req) else $error("request during retry started a refill"); // R12

endmodule

// File: tb/sim_tlb_lookup_unit.sv
`timescale 1ns/1ps
module sim_tlb_lookup_unit;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic [1:0]  req_kind;
  logic [1:0]  req_ring;
  logic        ring_asid_we;
  logic [31:0] ring_asid_wdata;
  logic [31:0] pt_base;
  logic        pte_req;
  logic [31:0] pte_addr;
  logic        pte_ack;
  logic [31:0] pte_data;
  logic        busy;
  logic        resp_valid;
  logic        resp_fault;
  logic [5:0]  resp_cause;
  logic [31:0] resp_paddr;

  tlb_lookup_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .req_ring(req_ring), .ring_asid_we(ring_asid_we),
    .ring_asid_wdata(ring_asid_wdata), .pt_base(pt_base), .pte_req(pte_req),
    .pte_addr(pte_addr), .pte_ack(pte_ack), .pte_data(pte_data), .busy(busy),
    .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_cause(resp_cause),
    .resp_paddr(resp_paddr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [31:0] va;
    logic [1:0]  kind;
    logic [1:0]  ring;
    logic [31:0] pte;
    logic        refill;
    logic [31:0] pte_at;
    logic        fault;
    logic [5:0]  cause;
    logic [31:0] pa;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{32'h0000_1234, 2'd0, 2'd0, 32'h0005_5013, 1'b1, 32'h8000_0004, 1'b0, 6'd0,  32'h0005_5234, 4'd10}, // R10 way1
    '{32'h0000_1ABC, 2'd1, 2'd1, 32'h0,         1'b0, 32'h0,         1'b0, 6'd0,  32'h0005_5ABC, 4'd2},  // R2 ring1 hit
    '{32'h0000_1008, 2'd2, 2'd0, 32'h0,         1'b0, 32'h0,         1'b0, 6'd0,  32'h0005_5008, 4'd6},  // R6 attr3 exec
    '{32'h0000_1010, 2'd0, 2'd2, 32'h0,         1'b0, 32'h0,         1'b1, 6'd26, 32'h0,         4'd5},  // R5
    '{32'h0000_2000, 2'd2, 2'd0, 32'h0007_700C, 1'b1, 32'h8000_0008, 1'b1, 6'd20, 32'h0,         4'd7},  // R7 attr12
    '{32'h0000_2010, 2'd1, 2'd0, 32'h0,         1'b0, 32'h0,         1'b1, 6'd29, 32'h0,         4'd7},  // R7
    '{32'h0000_2020, 2'd0, 2'd0, 32'h0,         1'b0, 32'h0,         1'b1, 6'd28, 32'h0,         4'd7},  // R7
    '{32'h0000_2000, 2'd2, 2'd1, 32'h0,         1'b0, 32'h0,         1'b1, 6'd18, 32'h0,         4'd5},  // R5 before rights
    '{32'h0000_3000, 2'd1, 2'd0, 32'h0009_900D, 1'b1, 32'h8000_000C, 1'b0, 6'd0,  32'h0009_9000, 4'd6},  // R6 attr13
    '{32'h0000_3004, 2'd2, 2'd0, 32'h0,         1'b0, 32'h0,         1'b1, 6'd20, 32'h0,         4'd6},  // R6
    '{32'h0000_3008, 2'd0, 2'd3, 32'h0,         1'b0, 32'h0,         1'b1, 6'd26, 32'h0,         4'd5},  // R5
    '{32'h8000_5000, 2'd0, 2'd0, 32'h0,         1'b0, 32'h0,         1'b1, 6'd24, 32'h0,         4'd3},  // R3 same region
    '{32'h8000_5000, 2'd2, 2'd1, 32'h000A_A031, 1'b1, 32'h8020_0014, 1'b0, 6'd0,  32'h000A_A000, 4'd9},  // R9 way0 wrap
    '{32'h8000_5FFC, 2'd1, 2'd1, 32'h0,         1'b0, 32'h0,         1'b1, 6'd29, 32'h0,         4'd6},  // R6 attr1
    '{32'h0000_4000, 2'd0, 2'd0, 32'h000B_B000, 1'b1, 32'h8000_0010, 1'b0, 6'd0,  32'h000B_B000, 4'd6},  // R6 attr0
    '{32'h0000_4000, 2'd2, 2'd0, 32'h0,         1'b0, 32'h0,         1'b1, 6'd20, 32'h0,         4'd6},  // R6
    '{32'h0000_6123, 2'd1, 2'd0, 32'h000C_C002, 1'b1, 32'h8000_0018, 1'b0, 6'd0,  32'h000C_C123, 4'd8},  // R8 attr2
    '{32'h0000_6000, 2'd2, 2'd0, 32'h0,         1'b0, 32'h0,         1'b1, 6'd20, 32'h0,         4'd6},  // R6
    '{32'h8000_6000, 2'd2, 2'd0, 32'h0,         1'b0, 32'h0,         1'b1, 6'd16, 32'h0,         4'd3}   // R3 fetch miss
  };

  task automatic run(input vec_t v, input bit spam);
    int    n, since_ack, refills;
    bit    got, hold_ok;
    logic [31:0] seen_at;
    string rq;
    rq = $sformatf("R%0d", v.rq);
    n = 0; since_ack = -1; refills = 0; got = 0; hold_ok = 1; seen_at = '0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = v.va; req_kind = v.kind; req_ring = v.ring;
    @(negedge clk);
    n = 1;
    if (spam) begin
      req_vaddr = 32'h0005_5000; req_kind = 2'd0; req_ring = 2'd0;
    end else begin
      req_valid = 1'b0;
    end
    while (!got && n < 40) begin
      if (resp_valid) begin
        got = 1;
      end else begin
        if (pte_req && !pte_ack) begin
          refills++;
          seen_at = pte_addr;
          repeat (2) begin
            @(negedge clk); n++;
            if (!pte_req || pte_addr != seen_at) hold_ok = 0;
          end
          pte_ack = 1'b1; pte_data = v.pte; since_ack = 0;
        end
        @(negedge clk); n++;
        pte_ack = 1'b0;
        if (since_ack >= 0) since_ack++;
      end
    end
    req_valid = 1'b0;
    check(got, "R11", "response seen", 32'(got), 32'd1);
    check(refills == int'(v.refill), "R9", "refill count", 32'(refills), 32'(v.refill));
    if (v.refill) begin
      check(seen_at == v.pte_at, "R9", "pte address", seen_at, v.pte_at);
      check(hold_ok, "R11", "pte request held", 32'(hold_ok), 32'd1);
      check(since_ack == 2, "R11", "latency after ack", 32'(since_ack), 32'd2);
    end else begin
      check(n == 1, "R11", "hit latency", 32'(n), 32'd1);
    end
    check(resp_fault == v.fault, rq, "fault flag", 32'(resp_fault), 32'(v.fault));
    check(resp_cause == v.cause, rq, "cause", 32'(resp_cause), 32'(v.cause));
    if (!v.fault) check(resp_paddr == v.pa, "R8", "paddr", resp_paddr, v.pa);
    if (spam) begin
      int extra;
      extra = 0;
      repeat (4) begin
        @(negedge clk);
        if (resp_valid || pte_req) extra++;
      end
      check(extra == 0, "R12", "activity from busy-time request", 32'(extra), 32'd0);
    end
  endtask

  task automatic write_map(input logic [31:0] m);
    @(negedge clk);
    ring_asid_we = 1'b1; ring_asid_wdata = m;
    @(negedge clk);
    ring_asid_we = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_kind = '0; req_ring = '0;
    ring_asid_we = 1'b0; ring_asid_wdata = '0; pt_base = 32'h8000_0000;
    pte_ack = 1'b0; pte_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!resp_valid, "R1", "resp_valid after reset", 32'(resp_valid), 32'd0);
    check(!pte_req,    "R1", "pte_req after reset",    32'(pte_req),    32'd0);
    check(!busy,       "R1", "busy after reset",       32'(busy),       32'd0);

    for (int i = 0; i < NV; i++) run(TBL[i], 1'b0);

    // R13 + R2: orphan the ring-1 entry at 0x1000 (ASID 2 absent), refill way3
    write_map(32'h0503_0901);
    run('{32'h0000_1000, 2'd0, 2'd0, 32'h000D_D010, 1'b1, 32'h8000_0004,
          1'b0, 6'd0, 32'h000D_D000, 4'd13}, 1'b0);
    // R4: both ASID 2 and ASID 9 now mapped -> two ways hit
    write_map(32'h0403_0902);
    run('{32'h0000_1000, 2'd0, 2'd0, 32'h0, 1'b0, 32'h0, 1'b1, 6'd25, 32'h0, 4'd4}, 1'b0);
    run('{32'h0000_1000, 2'd2, 2'd3, 32'h0, 1'b0, 32'h0, 1'b1, 6'd17, 32'h0, 4'd4}, 1'b0);
    // R12: request held high during refill (way0, ring0 ASID 2)
    run('{32'h0000_7000, 2'd0, 2'd0, 32'h000E_E003, 1'b1, 32'h8000_001C,
          1'b0, 6'd0, 32'h000E_E000, 4'd12}, 1'b1);
    // R10: reload at 0x7000 hits in way0 with ring 0
    run('{32'h0000_7044, 2'd1, 2'd0, 32'h0, 1'b0, 32'h0, 1'b0, 6'd0, 32'h000E_E044, 4'd10}, 1'b0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule